// File: doc/BRIEF.md
# Comma Word-Boundary Synchronizer

This block sits behind a deserializer whose 10-bit words carry code groups at an unknown bit phase. It keeps the previous raw word next to the current one. It searches every one of the ten possible bit offsets for a comma, and it locks the word boundary at the offset where the comma was found. The code groups it presents downstream are cut on that boundary.

A hysteretic synchronization machine decides whether the link is usable. It hunts for several commas on one consistent offset before it declares sync. While in sync, a downstream decoder reports through `cg_valid` whether each aligned code group was legal. The machine counts the illegal ones, lets a run of legal ones pay one error back, and drops sync only when the error count reaches its limit. The comma can be matched either as the short 7-bit comma or as the full 10-bit K28.5 group, in both disparities.

Top module: `comma_word_sync`

## Requirements
- R1: While `rst_n` is low, and on the first edge after its release, `sync_ok` and `pat_det` read 0. Reset also clears `aligned_word` and all internal counts.
- R2: With `long_mode`=1, a 10-bit window equal to 10'h17C or to its complement 10'h283 is a comma. The first-received bit is bit 0. The window is taken from the stream formed by the previous raw word (bits 0..9) and the current raw word (bits 10..18), at any offset from 0 to 9. `pat_det` is 1 one edge after the word that completes the comma is presented.
- R3: With `long_mode`=0, only the low seven bits of the window are compared, against 7'h7C or 7'h03. A group 10'h07C is therefore a comma in this mode but not with `long_mode`=1.
- R4: `aligned_word` is registered. After the edge on which the raw word completing code group G is presented, it equals G cut on the selected boundary.
- R5: Sync is declared on the edge that detects the third comma found on one unchanged offset.
- R6: While out of sync, a comma at an offset different from the one being counted restarts the count at one on the new offset.
- R7: While in sync, the boundary is frozen. Commas at other offsets raise no `pat_det` and do not disturb sync.
- R8: While in sync, each low `cg_valid` adds one error. Sync is lost on the edge of the third accumulated error.
- R9: While in sync with a nonzero error count, three consecutive high `cg_valid` samples remove one error. A low sample breaks the run.
- R10: `cg_valid` has no effect while out of sync.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Word clock |
| rst_n | input | 1 | Synchronous reset, active low |
| long_mode | input | 1 | 1: match the full 10-bit comma group; 0: match the 7-bit comma |
| raw_word | input | 10 | Unaligned deserialized word, bit 0 received first |
| cg_valid | input | 1 | Decoder verdict on the current `aligned_word` |
| aligned_word | output | 10 | Code group cut on the locked boundary |
| pat_det | output | 1 | Comma detected at the selected offset |
| sync_ok | output | 1 | Link synchronized |

## Verification
The bench drives commas at odd offsets and in both disparities. An aligner that searched too few offsets, or ignored the complement, would never assert sync there. It counts the exact edge of sync and of loss: a machine that was off by one pattern or one error would flip a cycle early or late. It moves the comma phase halfway through acquisition and again after lock. An aligner that kept counting after the move would lock too soon, and one that did not freeze its boundary would strobe on the stray commas. Error runs of 2 bad, 3 good, 2 bad and of 2 bad, 2 good, 1 bad separate a working error decrement from a missing one and from a run counter that is never cleared. A 10'h07C group shows whether the mode select really narrows the match.

// File: rtl/cws_pkg.sv
// Shared definitions for the comma word synchronizer.
// Assumes 8b/10b code groups with the first-received bit in bit 0.
package cws_pkg;
    typedef enum logic {
        ST_HUNT   = 1'b0,
        ST_LOCKED = 1'b1
    } sync_state_t;

    localparam logic [9:0] K28_5_NEG  = 10'h17C;
    localparam logic [6:0] COMMA7_NEG = 7'h7C;
endpackage

// File: rtl/cws_comma_search.sv
// Comma search: compares every candidate offset of the two-word window
// against the comma pattern and its complement.
// Assumes window bit 0 is the earliest received bit; purely combinational.
module cws_comma_search #(
    parameter int unsigned          W         = 10,
    parameter logic [W-1:0]         LONG_PAT  = cws_pkg::K28_5_NEG,
    parameter int unsigned          SHORT_LEN = 7,
    parameter logic [SHORT_LEN-1:0] SHORT_PAT = cws_pkg::COMMA7_NEG
) (
    input  logic [2*W-2:0] window,
    input  logic           long_mode,
    output logic [W-1:0]   hit_vec
);
    localparam logic [W-1:0]         LONG_INV  = ~LONG_PAT;
    localparam logic [SHORT_LEN-1:0] SHORT_INV = ~SHORT_PAT;

    for (genvar k = 0; k < W; k++) begin : g_off
        logic [W-1:0] slice;
        logic         m_long;
        logic         m_short;
        // Match the slice at offset k in either disparity.
        always_comb begin
            slice   = window[k +: W];
            m_long  = (slice == LONG_PAT) || (slice == LONG_INV);
            m_short = (slice[SHORT_LEN-1:0] == SHORT_PAT) ||
                      (slice[SHORT_LEN-1:0] == SHORT_INV);
            hit_vec[k] = long_mode ? m_long : m_short;
        end
    end
endmodule

// File: rtl/cws_align_path.sv
// Alignment datapath: holds the previous raw word, forms the search
// window and registers the code group cut at the selected offset.
// Assumes sel_off < W.
module cws_align_path #(
    parameter int unsigned W     = 10,
    parameter int unsigned OFF_W = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [W-1:0]     raw_word,
    input  logic [OFF_W-1:0] sel_off,
    output logic [2*W-2:0]   window,
    output logic [W-1:0]     aligned_word
);
    logic [W-1:0] prev_q;

    // Older word occupies the low bits, newer word the high bits.
    always_comb window = {raw_word[W-2:0], prev_q};

    // Keep the previous raw word and the aligned code group.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            prev_q       <= '0;
            aligned_word <= '0;
        end else begin
            prev_q       <= raw_word;
            aligned_word <= window[sel_off +: W];
        end
    end
endmodule

// File: rtl/cws_sync_fsm.sv
// Synchronization machine: hunts for a run of commas on one offset,
// then freezes the boundary and tracks code-group errors with hysteresis.
// Assumes ACQ_COUNT, LOSS_COUNT and GOOD_RUN are all at least 2.
module cws_sync_fsm #(
    parameter int unsigned W          = 10,
    parameter int unsigned OFF_W      = 4,
    parameter int unsigned ACQ_COUNT  = 3,
    parameter int unsigned LOSS_COUNT = 3,
    parameter int unsigned GOOD_RUN   = 3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [W-1:0]     hit_vec,
    input  logic             cg_valid,
    output logic [OFF_W-1:0] sel_off,
    output logic [OFF_W-1:0] lock_off,
    output logic             pat_det,
    output logic             sync_ok
);
    import cws_pkg::*;

    localparam int unsigned ACQ_W  = $clog2(ACQ_COUNT + 1);
    localparam int unsigned ERR_W  = $clog2(LOSS_COUNT + 1);
    localparam int unsigned GOOD_W = $clog2(GOOD_RUN + 1);
    localparam logic [ACQ_W-1:0]  ACQ_LAST  = ACQ_W'(ACQ_COUNT - 1);
    localparam logic [ERR_W-1:0]  ERR_LAST  = ERR_W'(LOSS_COUNT - 1);
    localparam logic [GOOD_W-1:0] GOOD_LAST = GOOD_W'(GOOD_RUN - 1);

    sync_state_t       state_q;
    logic [OFF_W-1:0]  lock_q;
    logic [ACQ_W-1:0]  acq_q;
    logic [ERR_W-1:0]  err_q;
    logic [GOOD_W-1:0] good_q;
    logic              det_q;
    logic [OFF_W-1:0]  first_off;
    logic              any_hit;
    logic              det;
    logic              hunting;

    // Lowest offset carrying a comma wins while hunting.
    always_comb begin
        first_off = '0;
        for (int i = W - 1; i >= 0; i--) begin
            if (hit_vec[i]) first_off = OFF_W'(i);
        end
        any_hit = |hit_vec;
    end

    // Pick the offset in use and the detect strobe for this word.
    always_comb begin
        hunting = (state_q == ST_HUNT);
        det     = hunting ? any_hit : hit_vec[lock_q];
        sel_off = (hunting && any_hit) ? first_off : lock_q;
    end

    // State, boundary and hysteresis counters.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_HUNT;
            lock_q  <= '0;
            acq_q   <= '0;
            err_q   <= '0;
            good_q  <= '0;
            det_q   <= 1'b0;
        end else begin
            det_q <= det;
            case (state_q)
                ST_HUNT: begin
                    if (any_hit) begin
                        lock_q <= first_off;
                        if ((first_off == lock_q) && (acq_q != '0)) begin
                            if (acq_q == ACQ_LAST) begin
                                state_q <= ST_LOCKED;
                                acq_q   <= '0;
                                err_q   <= '0;
                                good_q  <= '0;
                            end else begin
                                acq_q <= acq_q + 1'b1;
                            end
                        end else begin
                            acq_q <= ACQ_W'(1);
                        end
                    end
                end
                ST_LOCKED: begin
                    if (!cg_valid) begin
                        good_q <= '0;
                        if (err_q == ERR_LAST) begin
                            state_q <= ST_HUNT;
                            err_q   <= '0;
                            acq_q   <= '0;
                        end else begin
                            err_q <= err_q + 1'b1;
                        end
                    end else if (err_q != '0) begin
                        if (good_q == GOOD_LAST) begin
                            err_q  <= err_q - 1'b1;
                            good_q <= '0;
                        end else begin
                            good_q <= good_q + 1'b1;
                        end
                    end
                end
                default: state_q <= ST_HUNT;
            endcase
        end
    end

    always_comb begin
        lock_off = lock_q;
        pat_det  = det_q;
        sync_ok  = (state_q == ST_LOCKED);
    end
endmodule

// File: rtl/comma_word_sync.sv
// Top level: comma search, alignment datapath and sync machine.
// Assumes one raw word per clock, bit 0 first received; reset is
// synchronous and active low.
module comma_word_sync #(
    parameter int unsigned W          = 10,
    parameter int unsigned ACQ_COUNT  = 3,
    parameter int unsigned LOSS_COUNT = 3,
    parameter int unsigned GOOD_RUN   = 3
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         long_mode,
    input  logic [W-1:0] raw_word,
    input  logic         cg_valid,
    output logic [W-1:0] aligned_word,
    output logic         pat_det,
    output logic         sync_ok
);
    localparam int unsigned OFF_W = $clog2(W);

    logic [2*W-2:0]   window;
    logic [W-1:0]     hit_vec;
    logic [OFF_W-1:0] sel_off;
    logic [OFF_W-1:0] lock_off;

    cws_align_path #(.W(W), .OFF_W(OFF_W)) u_path (
        .clk          (clk),
        .rst_n        (rst_n),
        .raw_word     (raw_word),
        .sel_off      (sel_off),
        .window       (window),
        .aligned_word (aligned_word)
    );

    cws_comma_search #(.W(W)) u_search (
        .window    (window),
        .long_mode (long_mode),
        .hit_vec   (hit_vec)
    );

    cws_sync_fsm #(
        .W          (W),
        .OFF_W      (OFF_W),
        .ACQ_COUNT  (ACQ_COUNT),
        .LOSS_COUNT (LOSS_COUNT),
        .GOOD_RUN   (GOOD_RUN)
    ) u_fsm (
        .clk      (clk),
        .rst_n    (rst_n),
        .hit_vec  (hit_vec),
        .cg_valid (cg_valid),
        .sel_off  (sel_off),
        .lock_off (lock_off),
        .pat_det  (pat_det),
        .sync_ok  (sync_ok)
    );
endmodule

// File: rtl/cws_checker.sv
// Temporal checks on the synchronizer, bound to the top module.
// Assumes the bound instance exposes its locked offset as lock_off.
module cws_checker #(
    parameter int unsigned OFF_W = 4
) (
    input logic             clk,
    input logic             rst_n,
    input logic             cg_valid,
    input logic             pat_det,
    input logic             sync_ok,
    input logic [OFF_W-1:0] lock_off
);
    AST_RESET_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(rst_n) |-> (!sync_ok && !pat_det)); // R1

    AST_SYNC_ON_PATTERN: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(sync_ok) |-> pat_det); // R5

    AST_LOSS_ON_INVALID: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(sync_ok) |-> !$past(cg_valid)); // R8

    AST_BOUNDARY_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
        (sync_ok && $past(sync_ok)) |-> $stable(lock_off)); // R7
endmodule

bind comma_word_sync cws_checker #(.OFF_W(OFF_W)) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .cg_valid (cg_valid),
    .pat_det  (pat_det),
    .sync_ok  (sync_ok),
    .lock_off (lock_off)
);

// File: tb/comma_word_sync_test.sv
// Directed bench for comma_word_sync: one task per scenario.
module comma_word_sync_test;
    localparam int CLK_PERIOD = 10;
    localparam logic [9:0] K_NEG   = 10'h17C;
    localparam logic [9:0] K_POS   = 10'h283;
    localparam logic [9:0] K_SHORT = 10'h07C;
    localparam logic [9:0] D_FILL  = 10'h2AA;
    localparam logic [9:0] D_MARK  = 10'h155;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       long_mode = 1'b1;
    logic [9:0] raw_word = '0;
    logic       cg_valid = 1'b1;
    logic [9:0] aligned_word;
    logic       pat_det;
    logic       sync_ok;

    int         checks = 0;
    int         errors = 0;
    int         ph = 0;
    logic [9:0] prev_cg = D_FILL;
    bit         done = 1'b0;

    comma_word_sync uut (
        .clk          (clk),
        .rst_n        (rst_n),
        .long_mode    (long_mode),
        .raw_word     (raw_word),
        .cg_valid     (cg_valid),
        .aligned_word (aligned_word),
        .pat_det      (pat_det),
        .sync_ok      (sync_ok)
    );

    always #(CLK_PERIOD / 2) clk = ~clk;

    task automatic check(input string req, input string what,
                         input logic [9:0] act, input logic [9:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s actual %h expected %h", req, what, act, exp);
        end
    endtask

    // Present the raw word that completes code group cg at phase ph.
    task automatic send(input logic [9:0] cg, input logic v);
        logic [19:0] both;
        both = {cg, prev_cg};
        @(negedge clk);
        raw_word = 10'(both >> (10 - ph));
        cg_valid = v;
        prev_cg  = cg;
        @(posedge clk);
        #1;
    endtask

    task automatic do_reset(input logic mode);
        @(negedge clk);
        rst_n     = 1'b0;
        long_mode = mode;
        raw_word  = '0;
        cg_valid  = 1'b1;
        repeat (3) @(posedge clk);
        #1;
        check("R1", "sync in reset", {9'b0, sync_ok}, 10'd0);
        check("R1", "pat_det in reset", {9'b0, pat_det}, 10'd0);
        check("R1", "aligned in reset", aligned_word, 10'd0);
        @(negedge clk);
        rst_n   = 1'b1;
        prev_cg = D_FILL;
        @(posedge clk);
        #1;
        check("R1", "sync after release", {9'b0, sync_ok}, 10'd0);
    endtask

    // Three comma groups; sync must rise exactly on the third detection.
    task automatic acquire(input logic [9:0] kcg, input logic v_hunt, input string req);
        for (int g = 0; g < 3; g++) begin
            send(kcg, v_hunt);
            check(req, "no strobe before comma", {9'b0, pat_det}, 10'd0);
            send(D_FILL, v_hunt);
            check(req, "comma strobe", {9'b0, pat_det}, 10'd1);
            check("R5", "sync edge", {9'b0, sync_ok}, {9'b0, (g == 2)});
            check("R4", "aligned comma", aligned_word, kcg);
            send(D_FILL, (g == 2) ? 1'b1 : v_hunt);
        end
    endtask

    // Send n comma groups, checking strobe and sync at each detection.
    task automatic send_groups(input logic [9:0] kcg, input int n,
                               input logic exp_pat, input logic exp_sync, input string req);
        for (int g = 0; g < n; g++) begin
            send(kcg, 1'b1);
            send(D_FILL, 1'b1);
            check(req, "strobe at detection", {9'b0, pat_det}, {9'b0, exp_pat});
            check(req, "sync at detection", {9'b0, sync_ok}, {9'b0, exp_sync});
            send(D_FILL, 1'b1);
        end
    endtask

    task automatic t_negative_comma_and_loss();
        ph = 3;
        do_reset(1'b1);
        acquire(K_NEG, 1'b1, "R2");
        send(D_MARK, 1'b1);
        send(D_FILL, 1'b1);
        check("R4", "aligned data group", aligned_word, D_MARK);
        send(D_FILL, 1'b0);
        check("R8", "sync after 1 error", {9'b0, sync_ok}, 10'd1);
        send(D_FILL, 1'b0);
        check("R8", "sync after 2 errors", {9'b0, sync_ok}, 10'd1);
        send(D_FILL, 1'b0);
        check("R8", "sync after 3 errors", {9'b0, sync_ok}, 10'd0);
    endtask

    task automatic t_error_decrement();
        ph = 0;
        do_reset(1'b1);
        acquire(K_NEG, 1'b1, "R2");
        send(D_FILL, 1'b0);
        send(D_FILL, 1'b0);
        for (int i = 0; i < 3; i++) send(D_FILL, 1'b1);
        send(D_FILL, 1'b0);
        check("R9", "sync after paid-back error", {9'b0, sync_ok}, 10'd1);
        send(D_FILL, 1'b0);
        check("R9", "sync after third net error", {9'b0, sync_ok}, 10'd0);
    endtask

    task automatic t_broken_good_run();
        ph = 9;
        do_reset(1'b1);
        acquire(K_NEG, 1'b1, "R2");
        send(D_FILL, 1'b0);
        send(D_FILL, 1'b0);
        send(D_FILL, 1'b1);
        send(D_FILL, 1'b1);
        send(D_FILL, 1'b0);
        check("R9", "short good run gives no credit", {9'b0, sync_ok}, 10'd0);
    endtask

    task automatic t_positive_comma_valid_ignored();
        ph = 5;
        do_reset(1'b1);
        acquire(K_POS, 1'b0, "R10");
        check("R2", "sync on complemented comma", {9'b0, sync_ok}, 10'd1);
    endtask

    task automatic t_restart_then_frozen();
        ph = 3;
        do_reset(1'b1);
        send_groups(K_NEG, 2, 1'b1, 1'b0, "R6");
        ph = 6;
        send(D_FILL, 1'b1);
        acquire(K_NEG, 1'b1, "R6");
        ph = 1;
        send(D_FILL, 1'b1);
        send_groups(K_NEG, 3, 1'b0, 1'b1, "R7");
    endtask

    task automatic t_short_mode();
        ph = 2;
        do_reset(1'b0);
        acquire(K_SHORT, 1'b1, "R3");
        do_reset(1'b1);
        send_groups(K_SHORT, 3, 1'b0, 1'b0, "R3");
    endtask

    initial begin
        #(CLK_PERIOD * 100000);
        if (!done) begin
            errors++;
            $display("FAIL R5 watchdog actual timeout expected completion");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        t_negative_comma_and_loss();
        t_error_decrement();
        t_broken_good_run();
        t_positive_comma_valid_ignored();
        t_restart_then_frozen();
        t_short_mode();
        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule